// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects interrupt sources for a small peripheral chip and presents them to a host. The sources are a power-on indication, a FIFO data-available level, a one-cycle general system event and per-pin GPIO transitions. Each source latches into a sticky status bit. The host clears these bits through a byte-wide register bus that has an address, write data, read data, a write strobe and a read strobe. A single active-high interrupt line goes to the host.

The GPIO sources form a second level. They have their own enable and status registers, and these roll up into one summary bit of the system status register. The GPIO pins are asynchronous, so each passes through a two-flop synchronizer before its edges are detected. A two-state machine drives the interrupt line. Its states are IRQ_IDLE and IRQ_ACTIVE. The transition RAISE is taken when any enabled status bit is set. The transition DROP is taken when none is set.

Register addresses (byte): 0x09 system enable, 0x0A system status, 0x0B / 0x0C GPIO enable for pins 7:0 / 15:8, 0x0D / 0x0E GPIO status for pins 7:0 / 15:8.

Top module: `irqc_top`

## Requirements
- R1: After reset, the registers read as follows: system enable 0x01, system status 0x09 (bit 0 power-on and bit 3 internal both set), and all four GPIO bytes 0x00. Because of this, the interrupt line goes high one clock after reset is released.
- R2: A status bit sets when its source fires, even if its enable bit is clear. With the enable clear, the interrupt line stays low. Status bit 1 follows `fifo_avail`, bit 2 follows `gen_evt`, and bit 0 is set only by reset.
- R3: In both status registers, writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged, and a cleared power-on bit never sets again.
- R4: A write of 1 to status bit 1 has no effect while `fifo_avail` is high. The same write clears the bit once `fifo_avail` is low.
- R5: If a source fires in the same cycle as a write-1 clear of its bit, the bit stays set.
- R6: Bits 6:3 of the system enable register ignore writes and read as 0. Writing 0xFF reads back 0x87.
- R7: A rising edge or a falling edge on a GPIO pin sets that pin's status bit. The bit is visible on a read issued 4 cycles after the pin changes. Enable and status bits above the last pin read as 0.
- R8: System status bit 7 is 1 exactly when some GPIO status bit and its enable bit are both 1. Writing to bit 7 has no effect.
- R9: The interrupt line equals the OR of (system status AND system enable), delayed by one clock. It is high in IRQ_ACTIVE and low in IRQ_IDLE.
- R10: A read returns the addressed register on `bus_rdata` one clock after the read strobe. Unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| fifo_avail | input | 1 | FIFO holds data (level) |
| gen_evt | input | 1 | General system event (pulse) |
| gpio_pin | input | 3 | Asynchronous GPIO pin levels |
| irq_out | output | 1 | Interrupt to host, active high |

## Verification
Each result has a fixed latency:
- A register write takes effect at the next clock edge.
- Read data is due one edge after the read strobe.
- The interrupt line follows the status and enable state one edge later.
- A GPIO pin change reaches its status bit three edges later, through two synchronizer flops and the edge register.

The driver applies inputs on falling edges and queues the expected read value with its requirement tag. The monitor compares at the falling edge after the strobed rising edge. Interrupt checks are sampled at the falling edges just before and just after the expected change, so that the one-clock delay itself is checked. GPIO reads are issued four cycles after the pin change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SYS_EN     = 8'h09;
    localparam logic [ADDR_W-1:0] A_SYS_STA    = 8'h0A;
    localparam logic [ADDR_W-1:0] A_GP_EN_LO   = 8'h0B;
    localparam logic [ADDR_W-1:0] A_GP_EN_HI   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_GP_STA_LO  = 8'h0D;
    localparam logic [ADDR_W-1:0] A_GP_STA_HI  = 8'h0E;

    // stored system status bits (bit 7 is derived, bits 6:4 are zero)
    localparam int SYS_STORED = 4;
    localparam int B_POR  = 0;
    localparam int B_FIFO = 1;
    localparam int B_GEN  = 2;
    localparam int B_INTL = 3;
    localparam int B_GPIO = 7;

    localparam logic [DATA_W-1:0]     SYS_EN_WMASK = 8'h87;
    localparam logic [DATA_W-1:0]     SYS_EN_RST   = 8'h01;
    localparam logic [SYS_STORED-1:0] SYS_STA_RST  = 4'h9;

    localparam int MAX_GPIO = 2 * DATA_W;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irqc_gpio_edge.sv
module irqc_gpio_edge #(
    parameter int NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin,
    output logic [NUM_PINS-1:0] edge_o
);
    localparam int FILL_W   = 2;
    localparam int FILL_MAX = 3;

    logic [FILL_W-1:0] fill_q;
    logic              primed;

    // pipeline must hold real samples in all three stages before edges count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != FILL_W'(FILL_MAX)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign primed = (fill_q == FILL_W'(FILL_MAX));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign edge_o[i] = primed & (sync_q ^ prev_q);
    end

endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    // set has priority over clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= RST_VAL;
        end else begin
            q_q <= (q_q & ~clr_i) | set_i;
        end
    end

    assign q_o = q_q;

endmodule

// File: rtl/irqc_irq_fsm.sv
module irqc_irq_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE; // RAISE
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;   // DROP
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_GPIO = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                fifo_avail,
    input  logic                gen_evt,
    input  logic [NUM_GPIO-1:0] gpio_pin,
    output logic                irq_out
);
    localparam logic [MAX_GPIO-1:0] GP_MASK =
        MAX_GPIO'((32'd1 << NUM_GPIO) - 32'd1);

    // write decode
    logic wr_sys_en, wr_sys_sta, wr_gp_en_lo, wr_gp_en_hi, wr_gp_sta_lo, wr_gp_sta_hi;

    assign wr_sys_en    = bus_wr && (bus_addr == A_SYS_EN);
    assign wr_sys_sta   = bus_wr && (bus_addr == A_SYS_STA);
    assign wr_gp_en_lo  = bus_wr && (bus_addr == A_GP_EN_LO);
    assign wr_gp_en_hi  = bus_wr && (bus_addr == A_GP_EN_HI);
    assign wr_gp_sta_lo = bus_wr && (bus_addr == A_GP_STA_LO);
    assign wr_gp_sta_hi = bus_wr && (bus_addr == A_GP_STA_HI);

    // enable registers
    logic [DATA_W-1:0]   sys_en_q;
    logic [MAX_GPIO-1:0] gp_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_en_q <= SYS_EN_RST;
            gp_en_q  <= '0;
        end else begin
            if (wr_sys_en) begin
                sys_en_q <= bus_wdata & SYS_EN_WMASK;
            end
            if (wr_gp_en_lo) begin
                gp_en_q[DATA_W-1:0] <= bus_wdata & GP_MASK[DATA_W-1:0];
            end
            if (wr_gp_en_hi) begin
                gp_en_q[MAX_GPIO-1:DATA_W] <= bus_wdata & GP_MASK[MAX_GPIO-1:DATA_W];
            end
        end
    end

    // GPIO second level
    logic [NUM_GPIO-1:0] gp_edge;
    logic [NUM_GPIO-1:0] gp_clr;
    logic [NUM_GPIO-1:0] gp_sta_q;
    logic [MAX_GPIO-1:0] gp_sta_full;
    logic                gp_summary;

    irqc_gpio_edge #(
        .NUM_PINS (NUM_GPIO)
    ) u_gpio_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (gpio_pin),
        .edge_o (gp_edge)
    );

    always_comb begin
        for (int i = 0; i < NUM_GPIO; i++) begin
            if (i < DATA_W) begin
                gp_clr[i] = wr_gp_sta_lo & bus_wdata[i % DATA_W];
            end else begin
                gp_clr[i] = wr_gp_sta_hi & bus_wdata[i % DATA_W];
            end
        end
    end

    irqc_sticky #(
        .W       (NUM_GPIO),
        .RST_VAL ('0)
    ) u_gp_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (gp_edge),
        .clr_i (gp_clr),
        .q_o   (gp_sta_q)
    );

    always_comb begin
        gp_sta_full                 = '0;
        gp_sta_full[NUM_GPIO-1:0]   = gp_sta_q;
    end

    assign gp_summary = |(gp_sta_full & gp_en_q);

    // system first level
    logic [SYS_STORED-1:0] sys_set;
    logic [SYS_STORED-1:0] sys_clr;
    logic [SYS_STORED-1:0] sys_sta_q;
    logic [DATA_W-1:0]     sys_sta;

    always_comb begin
        sys_set         = '0;
        sys_set[B_FIFO] = fifo_avail;
        sys_set[B_GEN]  = gen_evt;
        sys_clr         = wr_sys_sta ? bus_wdata[SYS_STORED-1:0] : '0;
        // FIFO bit may only clear once the FIFO has drained
        if (fifo_avail) begin
            sys_clr[B_FIFO] = 1'b0;
        end
    end

    irqc_sticky #(
        .W       (SYS_STORED),
        .RST_VAL (SYS_STA_RST)
    ) u_sys_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sys_set),
        .clr_i (sys_clr),
        .q_o   (sys_sta_q)
    );

    always_comb begin
        sys_sta                   = '0;
        sys_sta[SYS_STORED-1:0]   = sys_sta_q;
        sys_sta[B_GPIO]           = gp_summary;
    end

    // interrupt output
    logic pending;

    assign pending = |(sys_sta & sys_en_q);

    irqc_irq_fsm u_irq_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq_out)
    );

    // read path
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        case (bus_addr)
            A_SYS_EN:    rd_mux = sys_en_q;
            A_SYS_STA:   rd_mux = sys_sta;
            A_GP_EN_LO:  rd_mux = gp_en_q[DATA_W-1:0];
            A_GP_EN_HI:  rd_mux = gp_en_q[MAX_GPIO-1:DATA_W];
            A_GP_STA_LO: rd_mux = gp_sta_full[DATA_W-1:0];
            A_GP_STA_HI: rd_mux = gp_sta_full[MAX_GPIO-1:DATA_W];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_GPIO = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fifo_avail,
    input logic                gen_evt,
    input logic [7:0]          sys_sta,
    input logic [7:0]          sys_en,
    input logic [NUM_GPIO-1:0] gp_edge,
    input logic [NUM_GPIO-1:0] gp_sta,
    input logic                irq
);
    AST_IRQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == (|($past(sys_sta & sys_en))))); // R9

    AST_FIFO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && fifo_avail) |-> sys_sta[1]); // R4

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && gen_evt) |-> sys_sta[2]); // R5

    AST_GPIO_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(gp_edge) & ~gp_sta) == '0)); // R7

    AST_POR_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sys_sta[0])) |-> !sys_sta[0]); // R3

endmodule

bind irqc_top irqc_checker #(
    .NUM_GPIO (NUM_GPIO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_avail (fifo_avail),
    .gen_evt    (gen_evt),
    .sys_sta    (sys_sta),
    .sys_en     (sys_en_q),
    .gp_edge    (gp_edge),
    .gp_sta     (gp_sta_q),
    .irq        (irq_out)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       fifo_avail = 1'b0;
    logic       gen_evt = 1'b0;
    logic [2:0] gpio_pin = '0;
    logic       irq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    irqc_top #(.NUM_GPIO(3)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .fifo_avail (fifo_avail),
        .gen_evt    (gen_evt),
        .gpio_pin   (gpio_pin),
        .irq_out    (irq_out)
    );

    // monitor: compare the read result due one edge after the strobe
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            nchk++;
            if (bus_rdata !== e) begin
                nerr++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        nchk++;
        if (irq_out !== e) begin
            nerr++;
            $display("FAIL %s: irq=%b expected=%b", t, irq_out, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: finished=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk_irq(1'b1, "R1 irq after reset");
        rd(8'h09, 8'h01, "R1 sys enable reset");
        rd(8'h0A, 8'h09, "R1 sys status reset");
        rd(8'h0B, 8'h00, "R1 gpio enable lo reset");
        rd(8'h0C, 8'h00, "R1 gpio enable hi reset");
        rd(8'h0D, 8'h00, "R1 gpio status lo reset");
        rd(8'h0E, 8'h00, "R1 gpio status hi reset");

        // R3 write-1-clear, write-0 no effect
        wr(8'h0A, 8'h00);
        rd(8'h0A, 8'h09, "R3 write zero keeps");
        wr(8'h0A, 8'h01);
        chk_irq(1'b1, "R9 irq before one-clock delay");
        idle(1);
        chk_irq(1'b0, "R9 irq drops after clear");
        rd(8'h0A, 8'h08, "R3 por cleared");
        wr(8'h0A, 8'h08);
        idle(3);
        rd(8'h0A, 8'h00, "R3 internal cleared, por stays clear");

        // R6 reserved enable bits
        wr(8'h09, 8'hFF);
        rd(8'h09, 8'h87, "R6 reserved enable bits");
        wr(8'h09, 8'h00);

        // R2 status sets while disabled
        @(negedge clk); gen_evt = 1'b1;
        @(negedge clk); gen_evt = 1'b0;
        idle(1);
        rd(8'h0A, 8'h04, "R2 gen status while disabled");
        chk_irq(1'b0, "R2 no irq while disabled");
        wr(8'h09, 8'h04);
        chk_irq(1'b0, "R9 irq not yet raised");
        idle(1);
        chk_irq(1'b1, "R9 irq raised one clock after enable");
        wr(8'h0A, 8'h04);
        idle(1);
        chk_irq(1'b0, "R9 irq cleared");

        // R4 fifo bit held while data remains
        @(negedge clk); fifo_avail = 1'b1;
        idle(2);
        wr(8'h0A, 8'h02);
        rd(8'h0A, 8'h02, "R4 fifo bit not cleared");
        @(negedge clk); fifo_avail = 1'b0;
        wr(8'h0A, 8'h02);
        rd(8'h0A, 8'h00, "R4 fifo bit cleared when empty");

        // R5 event beats simultaneous clear
        @(negedge clk);
        bus_addr  = 8'h0A;
        bus_wdata = 8'h04;
        bus_wr    = 1'b1;
        gen_evt   = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        gen_evt   = 1'b0;
        rd(8'h0A, 8'h04, "R5 event wins over clear");
        wr(8'h0A, 8'h04);
        rd(8'h0A, 8'h00, "R5 later clear works");

        // R7 / R8 gpio level
        wr(8'h09, 8'h00);
        @(negedge clk); gpio_pin = 3'b010;
        idle(4);
        rd(8'h0D, 8'h02, "R7 rising edge pin1");
        rd(8'h0A, 8'h00, "R8 summary clear while gpio disabled");
        wr(8'h0B, 8'h02);
        rd(8'h0A, 8'h80, "R8 summary set");
        wr(8'h0A, 8'h80);
        rd(8'h0A, 8'h80, "R8 write to summary ignored");
        wr(8'h09, 8'h80);
        idle(1);
        chk_irq(1'b1, "R9 irq from gpio summary");
        wr(8'h0D, 8'h02);
        rd(8'h0A, 8'h00, "R8 summary falls after gpio clear");
        chk_irq(1'b0, "R9 irq low after gpio clear");
        @(negedge clk); gpio_pin = 3'b000;
        idle(4);
        rd(8'h0D, 8'h02, "R7 falling edge pin1");
        wr(8'h0D, 8'h02);
        @(negedge clk); gpio_pin = 3'b101;
        idle(4);
        rd(8'h0D, 8'h05, "R7 two pins at once");
        rd(8'h0E, 8'h00, "R7 status above last pin");
        wr(8'h0B, 8'hFF);
        rd(8'h0B, 8'h07, "R7 enable above last pin");
        rd(8'h0A, 8'h80, "R8 summary from pins 0 and 2");
        wr(8'h0D, 8'h05);
        rd(8'h0D, 8'h00, "R3 gpio status cleared");

        // R10 unmapped
        rd(8'h20, 8'h00, "R10 unmapped address");
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule